// File: doc/BRIEF.md
# Equalizer Weight Load Controller

This block holds the coefficient table of a multi-lane feed-forward equalizer and the per-lane output scaling amounts. Software loads the table one entry at a time through a small register interface. It first writes a packed instruction word that selects a tap (depth position) and a lane. It then writes a signed weight into a data register. Finally it raises an execute bit and lowers it again. The table entry is written once, on the 0-to-1 change of the execute bit, using the instruction and data values held at that moment.

The whole table and all per-lane shift amounts are driven out continuously as flat vectors for the filter datapath, which lies outside this block. The tap field width follows from the filter length. With the default of 10 taps the field is 4 bits wide, and a tap index at or beyond the filter length causes no write. The configuration port is one write strobe with an address and a data word of the weight width.

Top module: `eqw_load_ctrl`

## Requirements
- R1: While `rst_ni` is low, every table entry, every shift amount and the execute bit read as zero.
- R2: The instruction register (address 0) holds the tap index in its low ceil(log2(TAPS)) bits, bits [3:0] by default, and the lane index directly above it, bits [7:4] by default.
- R3: A table write happens only on a write of 1 to bit 0 of the execute register (address 2) while that register holds 0. Writing 1 while it already holds 1, or writing 0, leaves the table unchanged.
- R4: A committed entry takes the value held in the data register (address 1) at the moment of the trigger. Later writes to the instruction or data registers do not change the table until the next trigger.
- R5: A trigger whose tap index is TAPS or larger (10 to 15 by default) writes nothing.
- R6: Weights are WEIGHT_W-bit (10-bit) two's-complement values, so that -512 and +511 are both stored and read back exactly.
- R7: A trigger changes only the addressed entry. Entry (lane, tap) appears at bit offset ((lane*TAPS)+tap)*WEIGHT_W of `weights_o`.
- R8: A write to address 16+L loads the low SHIFT_W (4) bits of the data word into the shift amount of lane L. That amount appears at bit offset L*SHIFT_W of `shifts_o`, and the other lanes keep their values.
- R9: Writes to addresses 3 to 15 change neither the table nor the shift amounts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe, one write per cycle |
| cfg_addr_i | input | 5 | Register address: 0 instruction, 1 data, 2 execute, 16+L lane L shift |
| cfg_wdata_i | input | WEIGHT_W (10) | Write data |
| weights_o | output | LANES*TAPS*WEIGHT_W (1600) | Full weight table, lane-major |
| shifts_o | output | LANES*SHIFT_W (64) | Per-lane shift amounts |

## Verification
The assertions check on every cycle that the table stays still unless a rising execute write occurs, and that a trigger with an out-of-range tap changes nothing. They also check that shift amounts move only on writes to their own addresses, that unmapped writes touch nothing, and that a committed entry equals the data register held at the trigger. Only the bench scenarios can show the exact bit placement of the instruction fields and table entries. The same holds for the signed extremes surviving the round trip, for the execute bit needing a fall before it can trigger again, and for a trigger leaving every other entry of a partly loaded table untouched.

// File: rtl/eqw_pkg.sv
package eqw_pkg;
    localparam int unsigned CFG_ADDR_W = 5;
    localparam logic [CFG_ADDR_W-1:0] ADDR_INSTR = 5'd0;
    localparam logic [CFG_ADDR_W-1:0] ADDR_DATA  = 5'd1;
    localparam logic [CFG_ADDR_W-1:0] ADDR_EXEC  = 5'd2;
    localparam int unsigned SHIFT_BASE = 16;
endpackage

// File: rtl/eqw_cfg_regs.sv
// Instruction, data and execute registers; raises commit_o for the cycle
// in which the execute bit is written from 0 to 1.
module eqw_cfg_regs #(
    parameter int TAP_W    = 4,
    parameter int LANE_W   = 4,
    parameter int WEIGHT_W = 10
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            cfg_we_i,
    input  logic [eqw_pkg::CFG_ADDR_W-1:0]  cfg_addr_i,
    input  logic [WEIGHT_W-1:0]             cfg_wdata_i,
    output logic                            commit_o,
    output logic [TAP_W-1:0]                tap_o,
    output logic [LANE_W-1:0]               lane_o,
    output logic [WEIGHT_W-1:0]             weight_o
);
    localparam int INSTR_W = TAP_W + LANE_W;

    typedef struct packed {
        logic [INSTR_W-1:0]  instr;
        logic [WEIGHT_W-1:0] data;
        logic                exec;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       commit_d;

    always_comb begin
        st_d     = st_q;
        commit_d = 1'b0;
        if (cfg_we_i) begin
            if (cfg_addr_i == eqw_pkg::ADDR_INSTR) begin
                st_d.instr = cfg_wdata_i[INSTR_W-1:0];
            end
            if (cfg_addr_i == eqw_pkg::ADDR_DATA) begin
                st_d.data = cfg_wdata_i;
            end
            if (cfg_addr_i == eqw_pkg::ADDR_EXEC) begin
                st_d.exec = cfg_wdata_i[0];
                commit_d  = cfg_wdata_i[0] & ~st_q.exec;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign commit_o = commit_d;
    assign tap_o    = st_q.instr[TAP_W-1:0];
    assign lane_o   = st_q.instr[TAP_W +: LANE_W];
    assign weight_o = st_q.data;
endmodule

// File: rtl/eqw_weight_array.sv
// Two-dimensional weight table written one entry per commit.
module eqw_weight_array #(
    parameter int TAPS     = 10,
    parameter int LANES    = 16,
    parameter int TAP_W    = 4,
    parameter int LANE_W   = 4,
    parameter int WEIGHT_W = 10
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              commit_i,
    input  logic [TAP_W-1:0]                  tap_i,
    input  logic [LANE_W-1:0]                 lane_i,
    input  logic [WEIGHT_W-1:0]               weight_i,
    output logic [LANES*TAPS*WEIGHT_W-1:0]    weights_o
);
    typedef struct packed {
        logic [LANES-1:0][TAPS-1:0][WEIGHT_W-1:0] w;
    } tbl_state_t;

    tbl_state_t tbl_d, tbl_q;
    logic       tap_ok, lane_ok;

    assign tap_ok = (32'(tap_i) < TAPS);

    // A lane field that exactly spans the lanes needs no range check.
    generate
        if (LANES == (1 << LANE_W)) begin : g_lane_full
            assign lane_ok = 1'b1;
        end else begin : g_lane_part
            assign lane_ok = (32'(lane_i) < LANES);
        end
    endgenerate

    always_comb begin
        tbl_d = tbl_q;
        if (commit_i && tap_ok && lane_ok) begin
            tbl_d.w[lane_i][tap_i] = weight_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tbl_q <= '0;
        else         tbl_q <= tbl_d;
    end

    assign weights_o = tbl_q.w;
endmodule

// File: rtl/eqw_shift_bank.sv
// Per-lane shift amounts, each at its own address above SHIFT_BASE.
module eqw_shift_bank #(
    parameter int LANES   = 16,
    parameter int SHIFT_W = 4
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            cfg_we_i,
    input  logic [eqw_pkg::CFG_ADDR_W-1:0]  cfg_addr_i,
    input  logic [SHIFT_W-1:0]              cfg_wdata_i,
    output logic [LANES*SHIFT_W-1:0]        shifts_o
);
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam logic [eqw_pkg::CFG_ADDR_W-1:0] MY_ADDR =
                eqw_pkg::CFG_ADDR_W'(eqw_pkg::SHIFT_BASE + l);
            logic [SHIFT_W-1:0] sh_d, sh_q;

            always_comb begin
                sh_d = sh_q;
                if (cfg_we_i && (cfg_addr_i == MY_ADDR)) sh_d = cfg_wdata_i;
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sh_q <= '0;
                else         sh_q <= sh_d;
            end

            assign shifts_o[l*SHIFT_W +: SHIFT_W] = sh_q;
        end
    endgenerate
endmodule

// File: rtl/eqw_load_ctrl.sv
// Top: equalizer weight load controller. LANES must not exceed 16.
module eqw_load_ctrl #(
    parameter int TAPS     = 10,
    parameter int LANES    = 16,
    parameter int WEIGHT_W = 10,
    parameter int SHIFT_W  = 4
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 cfg_we_i,
    input  logic [eqw_pkg::CFG_ADDR_W-1:0]       cfg_addr_i,
    input  logic [WEIGHT_W-1:0]                  cfg_wdata_i,
    output logic [LANES*TAPS*WEIGHT_W-1:0]       weights_o,
    output logic [LANES*SHIFT_W-1:0]             shifts_o
);
    localparam int TAP_W  = (TAPS  > 1) ? $clog2(TAPS)  : 1;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic                commit;
    logic [TAP_W-1:0]    tap;
    logic [LANE_W-1:0]   lane;
    logic [WEIGHT_W-1:0] weight;

    eqw_cfg_regs #(
        .TAP_W(TAP_W), .LANE_W(LANE_W), .WEIGHT_W(WEIGHT_W)
    ) cfg_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i),
        .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
        .commit_o(commit), .tap_o(tap), .lane_o(lane), .weight_o(weight)
    );

    eqw_weight_array #(
        .TAPS(TAPS), .LANES(LANES), .TAP_W(TAP_W), .LANE_W(LANE_W),
        .WEIGHT_W(WEIGHT_W)
    ) arr_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit), .tap_i(tap),
        .lane_i(lane), .weight_i(weight), .weights_o(weights_o)
    );

    eqw_shift_bank #(
        .LANES(LANES), .SHIFT_W(SHIFT_W)
    ) shb_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i),
        .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i[SHIFT_W-1:0]),
        .shifts_o(shifts_o)
    );
endmodule

// File: rtl/eqw_load_ctrl_chk.sv
// Checker with its own model of the configuration registers.
module eqw_load_ctrl_chk #(
    parameter int TAPS     = 10,
    parameter int LANES    = 16,
    parameter int WEIGHT_W = 10,
    parameter int SHIFT_W  = 4
) (
    input logic                                 clk_i,
    input logic                                 rst_ni,
    input logic                                 cfg_we_i,
    input logic [eqw_pkg::CFG_ADDR_W-1:0]       cfg_addr_i,
    input logic [WEIGHT_W-1:0]                  cfg_wdata_i,
    input logic [LANES*TAPS*WEIGHT_W-1:0]       weights_o,
    input logic [LANES*SHIFT_W-1:0]             shifts_o
);
    localparam int TAP_W  = (TAPS  > 1) ? $clog2(TAPS)  : 1;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int INSTR_W = TAP_W + LANE_W;

    logic [INSTR_W-1:0]  instr_m;
    logic [WEIGHT_W-1:0] data_m;
    logic                exec_m;
    logic                trig, tap_ok_m, unmapped, shift_wr;
    logic [WEIGHT_W-1:0] entry_now;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            instr_m <= '0;
            data_m  <= '0;
            exec_m  <= 1'b0;
        end else if (cfg_we_i) begin
            if (cfg_addr_i == eqw_pkg::ADDR_INSTR) instr_m <= cfg_wdata_i[INSTR_W-1:0];
            if (cfg_addr_i == eqw_pkg::ADDR_DATA)  data_m  <= cfg_wdata_i;
            if (cfg_addr_i == eqw_pkg::ADDR_EXEC)  exec_m  <= cfg_wdata_i[0];
        end
    end

    assign trig     = cfg_we_i && (cfg_addr_i == eqw_pkg::ADDR_EXEC) &&
                      cfg_wdata_i[0] && !exec_m;
    assign tap_ok_m = 32'(instr_m[TAP_W-1:0]) < TAPS;
    assign unmapped = (32'(cfg_addr_i) > 2) && (32'(cfg_addr_i) < eqw_pkg::SHIFT_BASE);
    assign shift_wr = cfg_we_i && (32'(cfg_addr_i) >= eqw_pkg::SHIFT_BASE);

    always_comb begin
        entry_now = '0;
        if (tap_ok_m) begin
            entry_now = weights_o[((32'(instr_m[TAP_W +: LANE_W]) * TAPS) +
                                   32'(instr_m[TAP_W-1:0])) * WEIGHT_W +: WEIGHT_W];
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (weights_o == '0 && shifts_o == '0));

    assert_no_trigger_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trig |=> $stable(weights_o));

    assert_commit_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig && tap_ok_m) |=> (entry_now == $past(data_m)));

    assert_bad_tap_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig && !tap_ok_m) |=> $stable(weights_o));

    assert_shift_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shift_wr |=> $stable(shifts_o));

    assert_unmapped_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && unmapped) |=> ($stable(weights_o) && $stable(shifts_o)));
endmodule

bind eqw_load_ctrl eqw_load_ctrl_chk #(
    .TAPS(TAPS), .LANES(LANES), .WEIGHT_W(WEIGHT_W), .SHIFT_W(SHIFT_W)
) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .weights_o(weights_o), .shifts_o(shifts_o)
);

// File: tb/eqw_load_ctrl_tb_top.sv
`timescale 1ns/1ps
module eqw_load_ctrl_tb_top;
    localparam int TAPS = 10, LANES = 16, WW = 10, SW = 4;

    logic                   clk = 1'b0;
    logic                   rst_ni = 1'b0;
    logic                   cfg_we = 1'b0;
    logic [4:0]             cfg_addr = '0;
    logic [WW-1:0]          cfg_wdata = '0;
    logic [LANES*TAPS*WW-1:0] weights;
    logic [LANES*SW-1:0]    shifts;

    int checks = 0, errors = 0;
    bit done = 0;
    int model_w [LANES][TAPS];
    int model_s [LANES];

    always #2.5 clk = ~clk;

    eqw_load_ctrl #(.TAPS(TAPS), .LANES(LANES), .WEIGHT_W(WW), .SHIFT_W(SW)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
        .cfg_wdata_i(cfg_wdata), .weights_o(weights), .shifts_o(shifts));

    function automatic int get_w(int lane, int tap);
        logic signed [WW-1:0] v;
        v = weights[((lane*TAPS)+tap)*WW +: WW];
        return int'(v);
    endfunction

    task automatic cfg_write(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = WW'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_table(input string req);
        int bad = 0, bl = 0, bt = 0, act = 0, exp_v = 0;
        checks++;
        for (int l = 0; l < LANES; l++)
            for (int t = 0; t < TAPS; t++)
                if (get_w(l, t) != model_w[l][t] && bad == 0) begin
                    bad = 1; bl = l; bt = t; act = get_w(l, t); exp_v = model_w[l][t];
                end
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: entry lane %0d tap %0d actual %0d expected %0d",
                     req, bl, bt, act, exp_v);
        end
    endtask

    task automatic check_shifts(input string req);
        int bad = 0, bl = 0, act = 0;
        checks++;
        for (int l = 0; l < LANES; l++)
            if (int'(shifts[l*SW +: SW]) != model_s[l] && bad == 0) begin
                bad = 1; bl = l; act = int'(shifts[l*SW +: SW]);
            end
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: shift lane %0d actual %0d expected %0d",
                     req, bl, act, model_s[bl]);
        end
    endtask

    task automatic check_entry(input string req, input int lane, input int tap, input int exp_v);
        checks++;
        if (get_w(lane, tap) != exp_v) begin
            errors++;
            $display("FAIL %s: entry lane %0d tap %0d actual %0d expected %0d",
                     req, lane, tap, get_w(lane, tap), exp_v);
        end
    endtask

    // Full load sequence: instruction (tap low 4 bits, lane bits 7:4), data, exec 1, exec 0.
    task automatic load(input int lane, input int tap, input int val);
        cfg_write(0, (lane << 4) | tap);
        cfg_write(1, val);
        cfg_write(2, 1);
        if (tap < TAPS) model_w[lane][tap] = val;
        cfg_write(2, 0);
    endtask

    task automatic t_reset;
        // R1: table and shifts zero during reset and right after it
        check_table("R1 table cleared");
        check_shifts("R1 shifts cleared");
    endtask

    task automatic t_basic;
        load(5, 3, -7);      // R2 field placement, R7 single entry
        check_entry("R2 lane5 tap3", 5, 3, -7);
        check_table("R7 only addressed entry");
        load(15, 9, 123);    // R2 highest lane and tap
        check_entry("R2 lane15 tap9", 15, 9, 123);
        load(0, 0, 42);
        check_table("R7 partial table");
    endtask

    task automatic t_signed;
        load(2, 1, -512);    // R6 extremes
        check_entry("R6 min weight", 2, 1, -512);
        load(2, 2, 511);
        check_entry("R6 max weight", 2, 2, 511);
        load(2, 1, -1);
        check_entry("R6 minus one", 2, 1, -1);
    endtask

    task automatic t_level;
        // R3: exec already 1, second write of 1 must not trigger
        cfg_write(0, (7 << 4) | 4);
        cfg_write(1, 100);
        cfg_write(2, 1);
        model_w[7][4] = 100;
        check_entry("R3 first trigger", 7, 4, 100);
        cfg_write(1, 200);
        cfg_write(2, 1);
        check_table("R3 repeated one ignored");
        cfg_write(2, 0);
        check_table("R3 write of zero ignored");
        cfg_write(2, 1);
        model_w[7][4] = 200;
        check_entry("R3 retrigger after fall", 7, 4, 200);
        cfg_write(2, 0);
    endtask

    task automatic t_snapshot;
        // R4: new instr/data without a trigger leave the table alone
        load(9, 6, 77);
        cfg_write(0, (9 << 4) | 7);
        cfg_write(1, -33);
        check_table("R4 no commit without trigger");
        cfg_write(2, 1);
        model_w[9][7] = -33;
        check_entry("R4 held values used", 9, 7, -33);
        check_entry("R4 previous entry kept", 9, 6, 77);
        cfg_write(2, 0);
    endtask

    task automatic t_bad_tap;
        load(1, 10, 55);     // R5 tap equal to length
        check_table("R5 tap 10 ignored");
        load(4, 15, -99);    // R5 largest tap code
        check_table("R5 tap 15 ignored");
    endtask

    task automatic t_shift;
        cfg_write(16 + 3, 7); model_s[3] = 7;          // R8
        check_shifts("R8 lane3 shift");
        cfg_write(16 + 15, 10'h3FA); model_s[15] = 4'hA; // R8 low 4 bits kept
        check_shifts("R8 lane15 low bits");
        cfg_write(16 + 0, 5); model_s[0] = 5;
        check_shifts("R8 lane0 independent");
        check_table("R8 table untouched by shift writes");
    endtask

    task automatic t_unmapped;
        for (int a = 3; a < 16; a++) cfg_write(a, 10'h155);
        check_table("R9 unmapped table");
        check_shifts("R9 unmapped shifts");
    endtask

    initial begin
        for (int l = 0; l < LANES; l++) begin
            model_s[l] = 0;
            for (int t = 0; t < TAPS; t++) model_w[l][t] = 0;
        end
        repeat (3) @(negedge clk);
        t_reset;
        rst_ni = 1'b1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_signed;
        t_level;
        t_snapshot;
        t_bad_tap;
        t_shift;
        t_unmapped;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule